// File: doc/BRIEF.md
# Programmable-Rate SPI Master Shift Engine

This block is a single-channel SPI master that runs from a fast peripheral clock. A client offers an 8-bit word on a valid/ready input port; once accepted, the engine lowers an active-low select, generates the serial bit clock from a programmable rate setting, shifts the word out on MOSI most significant bit first, and gathers eight MISO samples into a receive word. The receive word is presented with a one-cycle valid pulse when the select rises again.

The rate setting `cfg_brr` gives a bit-clock period of N = `cfg_brr`+1 peripheral cycles. The three lowest settings are floored to N = 4. When N is odd, the bit-clock half at the non-idle level lasts floor(N/2) cycles and the idle half lasts ceil(N/2) cycles. Polarity sets the idle level of the bit clock, and phase sets when the first MOSI bit appears. Rate, polarity and phase are captured when a word is accepted and hold for the whole transfer.

Back-pressure rules: `tx_ready` is high only while the engine is idle and master operation is enabled. A word moves when `tx_valid` and `tx_ready` are both high at a clock edge, and `tx_valid` asserted while `tx_ready` is low has no effect. The output side has no ready signal. `rx_valid` is a one-cycle pulse, and `rx_data` keeps its value until the next transfer completes.

Top module: `spi_baud_master`

## Requirements
- R1: `tx_ready` is high exactly when no transfer is running and `cfg_master` is 1. An accepted word makes `cs_n` go low on the same clock edge that accepts it.
- R2: For `cfg_brr` from 3 to 127, successive active edges of `sclk` are N = `cfg_brr`+1 peripheral cycles apart.
- R3: For `cfg_brr` of 0, 1 or 2, the bit-clock period is 4 peripheral cycles.
- R4: In each bit period, `sclk` first holds the non-idle level for floor(N/2) cycles and then the idle level for ceil(N/2) cycles. The first half is one cycle shorter when N is odd.
- R5: While idle, `sclk` rests at `cfg_cpol`. The active edge leaves the idle level: it is rising when `cfg_cpol` is 0 and falling when `cfg_cpol` is 1.
- R6: MOSI carries `tx_data` bit 7 first down to bit 0. Each bit after the first appears on the inactive (trailing) edge of the previous bit period, and MOSI never changes on an active edge. MOSI is 0 whenever `cs_n` is high.
- R7: With `cfg_cpha` 0, bit 7 is on MOSI from the cycle `cs_n` falls. With `cfg_cpha` 1, MOSI stays 0 for the first floor(N/2) cycles after `cs_n` falls and then shows bit 7 for ceil(N/2) cycles before the first active edge.
- R8: MISO is captured on the peripheral clock edge at which `sclk` makes each active transition. The first capture lands in `rx_data` bit 7.
- R9: `cs_n` stays low for exactly 9N cycles. That is one full bit period before the first active edge, then eight bit periods, ending ceil(N/2) cycles after the last trailing edge.
- R10: `rx_valid` is high for exactly one cycle, on the same edge that `cs_n` returns high. `rx_data` holds the eight captured bits from that edge onward.
- R11: `tx_valid` asserted during a transfer is ignored. The running transfer's MOSI stream, clock and select timing are unchanged, and no second transfer starts.
- R12: A change of `cfg_brr` during a transfer does not alter that transfer's timing. The new value applies from the next accepted word.
- R13: With `cfg_master` at 0, no word is accepted and `cs_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 enables master operation |
| cfg_cpol | input | 1 | Bit-clock idle level |
| cfg_cpha | input | 1 | Phase select for first-bit timing |
| cfg_brr | input | 7 | Rate setting; period N = max(4, value+1) |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine can accept a word |
| tx_data | input | 8 | Word to transmit, bit 7 first |
| rx_valid | output | 1 | One-cycle pulse: receive word complete |
| rx_data | output | 8 | Received word, first sample in bit 7 |
| sclk | output | 1 | Serial bit clock |
| cs_n | output | 1 | Active-low select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Cycle index t counts from 0 at the first sample after the accepting edge, so `cs_n` is due low at t = 0. The first active `sclk` edge is due at t = N, and each later edge comes N cycles after the one before it, with trailing edges floor(N/2) cycles into each period. `cs_n` and `rx_valid` are due at t = 9N, and `rx_valid` must be low again at t = 9N+1. The bench derives each expected level of `sclk`, `mosi` and `cs_n` from N and t, and samples every output on the falling clock edge. It also drives MISO for the edge due at t+1, so each capture can be predicted exactly. The sweep covers every rate setting from 0 to 20 in all four polarity and phase combinations, plus the largest settings. Some runs inject a busy-time offer and a rate change in the middle of the transfer.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LEAD = 2'd1,
    SEQ_BITS = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;

endpackage

// File: rtl/spi_bm_baud.sv
// Half-period timer: captures the rate setting at start and counts out
// alternating short/long halves of the bit clock.
module spi_bm_baud #(
  parameter int BRR_W     = 7,
  parameter int FLOOR_MAX = 2,
  parameter int MIN_DIV   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [BRR_W-1:0] brr_in,
  output logic             tick
);
  localparam int DIV_W = BRR_W + 1;

  logic [DIV_W-1:0] div_req;
  logic [BRR_W-1:0] h1_new, h2_new;
  logic [BRR_W-1:0] len_a, len_b, cnt;
  logic             ph;

  always_comb begin
    if (brr_in <= BRR_W'(FLOOR_MAX)) div_req = DIV_W'(MIN_DIV);
    else                             div_req = DIV_W'(brr_in) + DIV_W'(1);
    h1_new = div_req[DIV_W-1:1];
    h2_new = div_req[DIV_W-1:1] + {{(BRR_W-1){1'b0}}, div_req[0]};
  end

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_a <= BRR_W'(MIN_DIV / 2);
      len_b <= BRR_W'(MIN_DIV / 2);
      cnt   <= '0;
      ph    <= 1'b0;
    end else if (start) begin
      len_a <= h1_new;
      len_b <= h2_new;
      cnt   <= h1_new - BRR_W'(1);
      ph    <= 1'b0;
    end else if (run) begin
      if (cnt == '0) begin
        ph  <= ~ph;
        cnt <= (ph ? len_a : len_b) - BRR_W'(1);
      end else begin
        cnt <= cnt - BRR_W'(1);
      end
    end
  end

  p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && brr_in <= BRR_W'(FLOOR_MAX)) |=> (len_a == BRR_W'(2) && len_b == BRR_W'(2)));

  p_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (len_b >= len_a && (len_b - len_a) <= BRR_W'(1)));

  p_keep_rate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(len_a) && $stable(len_b)));

endmodule

// File: rtl/spi_bm_shifter.sv
// Transmit and receive shift registers plus the completed-word holder.
module spi_bm_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              shift,
  input  logic              sample,
  input  logic              commit,
  input  logic              miso,
  output logic              tx_msb,
  output logic              tx_next,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_sh, rx_sh;

  assign tx_msb  = tx_sh[DATA_W-1];
  assign tx_next = tx_sh[DATA_W-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_word <= '0;
    end else begin
      if (load)       tx_sh <= tx_word;
      else if (shift) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      if (sample)     rx_sh <= {rx_sh[DATA_W-2:0], miso};
      if (commit)     rx_word <= rx_sh;
    end
  end

  p_commit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(rx_word));

endmodule

// File: rtl/spi_bm_seq.sv
// Transfer sequencer: walks the lead-in halves and the bit halves, and
// drives select, bit clock and MOSI from registers.
module spi_bm_seq
  import spi_bm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en,
  input  logic cfg_cpol,
  input  logic cfg_cpha,
  input  logic tx_valid,
  input  logic first_bit,
  input  logic tick,
  input  logic tx_msb,
  input  logic tx_next,
  output logic tx_ready,
  output logic start,
  output logic busy,
  output logic shift_en,
  output logic sample_en,
  output logic finish,
  output logic sclk,
  output logic cs_n,
  output logic mosi,
  output logic done
);
  localparam int HALVES = 2 * (DATA_W + 1);
  localparam int IDX_W  = $clog2(HALVES + 1);

  seq_state_t       state_q;
  spi_mode_t        mode_q;
  logic [IDX_W-1:0] hidx_q, nxt;
  logic             last_half, step, enter_active, enter_idle, enter_lead2;

  always_comb begin
    tx_ready     = master_en && (state_q == SEQ_IDLE);
    start        = tx_valid && tx_ready;
    busy         = (state_q != SEQ_IDLE);
    last_half    = (hidx_q == IDX_W'(HALVES - 1));
    finish       = busy && tick && last_half;
    step         = busy && tick && !last_half;
    nxt          = hidx_q + IDX_W'(1);
    enter_lead2  = step && (nxt == IDX_W'(1));
    enter_active = step && (nxt >= IDX_W'(2)) && !nxt[0];
    enter_idle   = step && (nxt >= IDX_W'(3)) && nxt[0];
    sample_en    = enter_active;
    shift_en     = enter_idle && (nxt != IDX_W'(HALVES - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      mode_q  <= '0;
      hidx_q  <= '0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      state_q <= SEQ_LEAD;
      mode_q  <= '{cpol: cfg_cpol, cpha: cfg_cpha};
      hidx_q  <= '0;
      sclk    <= cfg_cpol;
      cs_n    <= 1'b0;
      mosi    <= cfg_cpha ? 1'b0 : first_bit;
      done    <= 1'b0;
    end else if (finish) begin
      state_q <= SEQ_IDLE;
      hidx_q  <= '0;
      sclk    <= mode_q.cpol;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      done    <= 1'b1;
    end else begin
      done <= 1'b0;
      if (state_q == SEQ_IDLE) sclk <= cfg_cpol;
      if (step) begin
        hidx_q <= nxt;
        if (nxt == IDX_W'(2)) state_q <= SEQ_BITS;
      end
      if (enter_lead2 && mode_q.cpha) mosi <= tx_msb;
      if (enter_active) sclk <= ~mode_q.cpol;
      if (enter_idle)   sclk <= mode_q.cpol;
      if (shift_en)     mosi <= tx_next;
    end
  end

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> cs_n);

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_valid) |-> !start);

  p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$stable(sclk) && sclk == ~mode_q.cpol) |-> $stable(mosi));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));

  p_idle_mosi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi);

endmodule

// File: rtl/spi_baud_master.sv
module spi_baud_master #(
  parameter int DATA_W = 8,
  parameter int BRR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [BRR_W-1:0]  cfg_brr,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  logic start, busy, tick, shift_en, sample_en, finish, tx_msb, tx_next;

  spi_bm_baud #(.BRR_W(BRR_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .run    (busy),
    .brr_in (cfg_brr),
    .tick   (tick)
  );

  spi_bm_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_en (cfg_master),
    .cfg_cpol  (cfg_cpol),
    .cfg_cpha  (cfg_cpha),
    .tx_valid  (tx_valid),
    .first_bit (tx_data[DATA_W-1]),
    .tick      (tick),
    .tx_msb    (tx_msb),
    .tx_next   (tx_next),
    .tx_ready  (tx_ready),
    .start     (start),
    .busy      (busy),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .finish    (finish),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .done      (rx_valid)
  );

  spi_bm_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .tx_word (tx_data),
    .shift   (shift_en),
    .sample  (sample_en),
    .commit  (finish),
    .miso    (miso),
    .tx_msb  (tx_msb),
    .tx_next (tx_next),
    .rx_word (rx_data)
  );

  p_master_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && cs_n) |=> cs_n);

endmodule

// File: tb/spi_baud_master_test.sv
module spi_baud_master_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [6:0] cfg_brr = 7'd0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       miso = 1'b0;
  logic       tx_ready, rx_valid, sclk, cs_n, mosi;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_baud_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_brr(cfg_brr), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk),
    .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One transfer; every output compared each cycle against values derived from N and t.
  task automatic run_xfer(input logic [7:0] tx, input logic [7:0] slave, input int brr,
                          input bit cpol, input bit cpha, input bit poke);
    int n, h1;
    bit ok_cs, ok_v, ok_sc, ok_mo, ok_rx, ok_rdy;
    int a_cs, e_cs, a_v, e_v, a_sc, e_sc, a_mo, e_mo, a_rx;
    n = (brr < 3) ? 4 : brr + 1;
    h1 = n / 2;
    ok_cs = 1; ok_v = 1; ok_sc = 1; ok_mo = 1; ok_rx = 1; ok_rdy = 1;
    a_cs = 0; e_cs = 0; a_v = 0; e_v = 0; a_sc = 0; e_sc = 0; a_mo = 0; e_mo = 0; a_rx = 0;
    @(negedge clk);
    cfg_brr = 7'(brr); cfg_cpol = cpol; cfg_cpha = cpha;
    @(negedge clk);
    // R5: idle level follows polarity; R1: ready while idle
    check(sclk == cpol && tx_ready == 1'b1, "R5 R1 idle sclk/ready", {sclk, tx_ready}, {cpol, 1'b1});
    tx_valid = 1'b1; tx_data = tx;
    @(posedge clk);
    for (int t = 0; t <= 9 * n + 1; t++) begin
      int u, j, off, e;
      logic xs, xm;
      @(negedge clk);
      if (t == 0) tx_valid = 1'b0;
      if (poke && t == 3) begin
        // R11 offer while busy, R12 rate change mid-transfer
        tx_valid = 1'b1; tx_data = ~tx; cfg_brr = 7'((brr + 9) % 128);
        if (tx_ready !== 1'b0) ok_rdy = 0;
      end
      if (poke && t == n + 2) tx_valid = 1'b0;
      // select and done pulse (R9, R10)
      if (cs_n !== ((t < 9 * n) ? 1'b0 : 1'b1) && ok_cs) begin
        ok_cs = 0; a_cs = t; e_cs = (t < 9 * n) ? 0 : 1;
      end
      if (rx_valid !== ((t == 9 * n) ? 1'b1 : 1'b0) && ok_v) begin
        ok_v = 0; a_v = t; e_v = 9 * n;
      end
      if (t == 9 * n && rx_data !== slave) begin ok_rx = 0; a_rx = rx_data; end
      // bit clock (R2 R3 R4 R5)
      if (t < n || t >= 9 * n) xs = cpol;
      else xs = (((t - n) % n) < h1) ? ~cpol : cpol;
      if (sclk !== xs && ok_sc) begin ok_sc = 0; a_sc = t; e_sc = xs; end
      // data out (R6 R7)
      if (t >= 9 * n) xm = 1'b0;
      else if (t < n) xm = (cpha && t < h1) ? 1'b0 : tx[7];
      else begin
        u = t - n; j = u / n; off = u % n;
        xm = (off < h1 || j == 7) ? tx[7 - j] : tx[6 - j];
      end
      if (mosi !== xm && ok_mo) begin ok_mo = 0; a_mo = t; e_mo = xm; end
      // drive MISO for the edge after this sample (R8)
      e = t + 1 - n;
      j = (e < 0) ? 0 : e / n;
      if (j > 7) j = 7;
      miso = slave[7 - j];
    end
    check(ok_cs, poke ? "R9 R11 R12 cs_n low window (fail cycle)" : "R9 R1 cs_n low window (fail cycle)", a_cs, e_cs);
    check(ok_v, "R10 rx_valid pulse cycle", a_v, e_v);
    check(ok_sc, (brr < 3) ? "R3 R4 R5 sclk level at cycle" : "R2 R4 R5 sclk level at cycle", a_sc, e_sc);
    check(ok_mo, poke ? "R6 R7 R11 mosi at cycle" : "R6 R7 mosi at cycle", a_mo, e_mo);
    check(ok_rx, "R8 rx_data word", a_rx, slave);
    if (poke) check(ok_rdy, "R11 tx_ready low while busy", 1, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(cs_n == 1'b1 && mosi == 1'b0 && rx_valid == 1'b0, "R9 R10 reset outputs",
          {cs_n, mosi, rx_valid}, 3'b100);
    check(tx_ready == 1'b1, "R1 ready after reset", tx_ready, 1);

    // R13: master disabled, offers refused
    begin
      bit ok13 = 1;
      cfg_master = 1'b0; tx_valid = 1'b1; tx_data = 8'hA5;
      repeat (20) begin
        @(negedge clk);
        if (tx_ready !== 1'b0 || cs_n !== 1'b1) ok13 = 0;
      end
      tx_valid = 1'b0; cfg_master = 1'b1;
      check(ok13, "R13 no transfer when master off", cs_n, 1);
    end

    // Sweep small rates in every mode; includes R3 floor settings 0..2
    for (int b = 0; b <= 20; b++) begin
      for (int m = 0; m < 4; m++) begin
        run_xfer(8'(b * 37 + m * 11 + 5), ~8'(b * 53 + m), b, m[1], m[0], (b % 5) == 2);
      end
    end
    // Large rates (R2 upper range, R4 odd split)
    run_xfer(8'h96, 8'h3C, 63, 1'b0, 1'b1, 1'b0);
    run_xfer(8'h01, 8'h80, 126, 1'b1, 1'b0, 1'b1);
    run_xfer(8'hFF, 8'h00, 127, 1'b1, 1'b1, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule